// File: doc/BRIEF.md
# UART configuration register bank

This block is the software-facing register file of a UART. A simple APB-style port reaches it: a write lands on the clock edge where `psel`, `penable` and `pwrite` are all high, and a read returns `prdata` combinationally from `paddr`. It holds the baud divisors, line control, control, FIFO threshold select, interrupt mask and status, DMA control and a block of read-only identification bytes. It drives the committed settings out to the serial engine.

The two baud divisors are staged in shadow registers. They reach the engine only when line control is written. That single write loads the shadows and the new line-control byte together into one 30-bit configuration word, so the engine never sees a half-updated baud setting.

Writes to the data register go one of two ways. If the committed line control selects FIFOs, they become a one-cycle push towards the transmit FIFO. Otherwise they land in a single holding register.

Top module: `uart_regbank`

## Requirements
- R1: After reset, control reads 0x0300, FIFO level select reads 0x0012, and every other register, `cfg_word`, `cfg_err` and `irq` are zero.
- R2: A write to the integer divisor (0x024, 16 bits) or the fractional divisor (0x028, 6 bits) updates only its shadow, and that shadow reads back. `cfg_word` is left unchanged.
- R3: A write to line control (0x02C, 8 bits) sets `cfg_word`, on the same edge, to {integer shadow [29:14], fractional shadow [13:8], written byte [7:0]}. Line control reads back as `cfg_word[7:0]`.
- R4: While control bit 1 (enable) is set, writes to 0x024, 0x028 and 0x02C are discarded and `cfg_err` is set. `cfg_err` stays set until reset.
- R5: A write to the data offset 0x000 raises `tx_push` for that access cycle with `tx_wdata` equal to the written word, provided `cfg_word` bit 4 (FIFO enable) is 1. If that bit is 0, the write raises `hold_load` instead and loads `tx_hold`. The two strobes are never high together.
- R6: The raw status (0x03C, 11 bits) sets each bit on which `irq_set` is high. Writing to the clear offset 0x044 clears each raw bit whose data bit is 1, and data bits of 0 have no effect. A bit that is set and cleared on the same edge ends up set.
- R7: The masked status at 0x040 reads raw AND mask, where the mask is at 0x038 with 11 bits. `irq` is high exactly when that AND is non-zero.
- R8: Control (0x030), FIFO level select (0x034) and DMA control (0x048) are 16-bit read/write registers. Control, FIFO level select and DMA control also appear on the `ctrl`, `ifls` and `dma_ctrl` outputs.
- R9: Reads of 0x000, of 0x044, of the reserved range 0x04C–0x07C and of any other unmapped offset return zero. Writes to the reserved range change no register.
- R10: Offsets 0xFE0 + 4k, for k from 0 to 7, return byte k of parameter `ID_BYTES` (bits 8k+7..8k) in the low byte, with the high byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Access select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 16 | Write data |
| prdata | output | 16 | Read data (combinational) |
| irq_set | input | 11 | Per-bit interrupt event pulses from the engine |
| cfg_word | output | 30 | Committed divisor and line-control word |
| ctrl | output | 16 | Control register |
| ifls | output | 16 | FIFO level select register |
| dma_ctrl | output | 16 | DMA control register |
| irq | output | 1 | OR of masked status |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_wdata | output | 16 | Data for the push |
| hold_load | output | 1 | Holding register load strobe |
| tx_hold | output | 16 | Transmit holding register |
| cfg_err | output | 1 | Sticky flag for a configuration write made while enabled |

## Verification
The hardest case to reach is an event arriving on the same edge as a clear of the same raw bit. The bench brings it about by holding `irq_set` high through the whole clear-register write, so the access-phase edge carries both at once. A second hard case is a divisor write made while enabled, followed by an interleaved disable and commit. Long random runs of mixed writes, with control bit 1 toggled at random, reach the locked state and the later line-control commit in many orders. After every step the bench compares all readable registers and outputs against a model.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int INT_W = 11,
  parameter int IBRD_W = 16,
  parameter int FBRD_W = 6,
  parameter int LCR_W = 8,
  parameter int FEN_BIT = 4,
  parameter int EN_BIT = 1,
  parameter logic [63:0] ID_BYTES = 64'hC3_42_19_7E_00_01_3C_A5,
  localparam int CFG_W = IBRD_W + FBRD_W + LCR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [INT_W-1:0]  irq_set,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [DW-1:0]     ctrl,
  output logic [DW-1:0]     ifls,
  output logic [DW-1:0]     dma_ctrl,
  output logic              irq,
  output logic              tx_push,
  output logic [DW-1:0]     tx_wdata,
  output logic              hold_load,
  output logic [DW-1:0]     tx_hold,
  output logic              cfg_err
);

  localparam logic [AW-1:0] A_DATA = AW'('h000);
  localparam logic [AW-1:0] A_IBRD = AW'('h024);
  localparam logic [AW-1:0] A_FBRD = AW'('h028);
  localparam logic [AW-1:0] A_LCR  = AW'('h02C);
  localparam logic [AW-1:0] A_CTRL = AW'('h030);
  localparam logic [AW-1:0] A_IFLS = AW'('h034);
  localparam logic [AW-1:0] A_MASK = AW'('h038);
  localparam logic [AW-1:0] A_RAW  = AW'('h03C);
  localparam logic [AW-1:0] A_MIS  = AW'('h040);
  localparam logic [AW-1:0] A_CLR  = AW'('h044);
  localparam logic [AW-1:0] A_DMA  = AW'('h048);
  localparam logic [AW-1:0] A_ID   = AW'('hFE0);
  localparam logic [DW-1:0] CTRL_RST = DW'('h0300);
  localparam logic [DW-1:0] IFLS_RST = DW'('h0012);

  logic [IBRD_W-1:0] ibrd_sh;
  logic [FBRD_W-1:0] fbrd_sh;
  logic [INT_W-1:0]  raw, mask, clr;
  logic wr, en, cfg_wr, lcr_ok, data_wr;

  assign wr      = psel && penable && pwrite;
  assign en      = ctrl[EN_BIT];
  assign cfg_wr  = wr && (paddr == A_IBRD || paddr == A_FBRD || paddr == A_LCR);
  assign lcr_ok  = wr && !en && paddr == A_LCR;
  assign data_wr = wr && paddr == A_DATA;
  assign clr     = (wr && paddr == A_CLR) ? pwdata[INT_W-1:0] : '0;

  assign tx_push   = data_wr && cfg_word[FEN_BIT];
  assign hold_load = data_wr && !cfg_word[FEN_BIT];
  assign tx_wdata  = pwdata;
  assign irq       = |(raw & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibrd_sh  <= '0;
      fbrd_sh  <= '0;
      cfg_word <= '0;
      ctrl     <= CTRL_RST;
      ifls     <= IFLS_RST;
      dma_ctrl <= '0;
      mask     <= '0;
      raw      <= '0;
      tx_hold  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      raw     <= (raw & ~clr) | irq_set;
      cfg_err <= cfg_err | (cfg_wr && en);
      if (hold_load) tx_hold <= pwdata;
      if (wr) begin
        case (paddr)
          A_IBRD: if (!en) ibrd_sh <= pwdata[IBRD_W-1:0];
          A_FBRD: if (!en) fbrd_sh <= pwdata[FBRD_W-1:0];
          A_LCR:  if (!en) cfg_word <= {ibrd_sh, fbrd_sh, pwdata[LCR_W-1:0]};
          A_CTRL: ctrl <= pwdata;
          A_IFLS: ifls <= pwdata;
          A_MASK: mask <= pwdata[INT_W-1:0];
          A_DMA:  dma_ctrl <= pwdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_IBRD: prdata = DW'(ibrd_sh);
      A_FBRD: prdata = DW'(fbrd_sh);
      A_LCR:  prdata = DW'(cfg_word[LCR_W-1:0]);
      A_CTRL: prdata = ctrl;
      A_IFLS: prdata = ifls;
      A_MASK: prdata = DW'(mask);
      A_RAW:  prdata = DW'(raw);
      A_MIS:  prdata = DW'(raw & mask);
      A_DMA:  prdata = dma_ctrl;
      default:
        if (paddr >= A_ID && paddr[1:0] == 2'b00)
          prdata = DW'(ID_BYTES[{paddr[4:2], 3'b000} +: 8]);
    endcase
  end

  p_commit_only_lcr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(lcr_ok));

  p_locked_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(cfg_word));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err);

  p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push, hold_load}));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & $past(clr & ~irq_set)) == '0);

  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_set) & ~raw) == '0);

endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] IDB = 64'hC3_42_19_7E_00_01_3C_A5;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [15:0] pwdata = '0, prdata;
  logic [10:0] irq_set = '0;
  logic [29:0] cfg_word;
  logic [15:0] ctrl, ifls, dma_ctrl, tx_wdata, tx_hold;
  logic irq, tx_push, hold_load, cfg_err;

  uart_regbank i_uart_regbank (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .irq_set, .cfg_word, .ctrl, .ifls, .dma_ctrl, .irq, .tx_push,
    .tx_wdata, .hold_load, .tx_hold, .cfg_err);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ibrd, m_ctrl, m_ifls, m_dma, m_hold;
  logic [5:0]  m_fbrd;
  logic [29:0] m_cfg;
  logic [10:0] m_ris, m_imsc;
  logic        m_err;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(logic [11:0] a);
    case (a)
      12'h024: return m_ibrd;
      12'h028: return {10'd0, m_fbrd};
      12'h02C: return {8'd0, m_cfg[7:0]};
      12'h030: return m_ctrl;
      12'h034: return m_ifls;
      12'h038: return {5'd0, m_imsc};
      12'h03C: return {5'd0, m_ris};
      12'h040: return {5'd0, m_ris & m_imsc};
      12'h048: return m_dma;
      default:
        if (a >= 12'hFE0 && a[1:0] == 0) return {8'd0, IDB[a[4:2]*8 +: 8]};
        else return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h024, 12'h028: return "R2";
      12'h02C: return "R3";
      12'h03C: return "R6";
      12'h040: return "R7";
      12'h030, 12'h034, 12'h038, 12'h048: return "R8";
      default: return (a >= 12'hFE0) ? "R10" : "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_ibrd = 0; m_fbrd = 0; m_cfg = 0; m_ctrl = 16'h0300; m_ifls = 16'h0012;
    m_dma = 0; m_hold = 0; m_ris = 0; m_imsc = 0; m_err = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    #1 chk(tag_of(a), prdata, exp_read(a));
    psel = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    logic en;
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    #1;
    if (a == 12'h000) begin
      chk("R5 push", tx_push, m_cfg[4]);
      chk("R5 load", hold_load, !m_cfg[4]);
      chk("R5 wdata", tx_wdata, d);
    end
    @(posedge clk);
    en = m_ctrl[1];
    m_ris = (m_ris & ~((a == 12'h044) ? d[10:0] : 11'h0)) | irq_set;
    case (a)
      12'h000: if (!m_cfg[4]) m_hold = d;
      12'h024: if (en) m_err = 1; else m_ibrd = d;
      12'h028: if (en) m_err = 1; else m_fbrd = d[5:0];
      12'h02C: if (en) m_err = 1; else m_cfg = {m_ibrd, m_fbrd, d[7:0]};
      12'h030: m_ctrl = d;
      12'h034: m_ifls = d;
      12'h038: m_imsc = d[10:0];
      12'h048: m_dma = d;
      default: ;
    endcase
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic pulse(logic [10:0] m);
    @(negedge clk); irq_set = m;
    @(negedge clk); irq_set = 0; m_ris |= m;
  endtask

  task automatic check_outs();
    @(negedge clk); #1;
    chk("R3 cfg_word", cfg_word, m_cfg);
    chk("R4 cfg_err", cfg_err, m_err);
    chk("R8 ctrl", ctrl, m_ctrl);
    chk("R8 ifls", ifls, m_ifls);
    chk("R8 dma", dma_ctrl, m_dma);
    chk("R7 irq", irq, |(m_ris & m_imsc));
    chk("R5 hold", tx_hold, m_hold);
  endtask

  task automatic check_all();
    foreach (reg_list[i]) rd(reg_list[i]);
    check_outs();
  endtask

  logic [11:0] reg_list [12] = '{12'h000, 12'h024, 12'h028, 12'h02C, 12'h030,
    12'h034, 12'h038, 12'h03C, 12'h040, 12'h044, 12'h048, 12'h050};
  logic [11:0] wr_list [11] = '{12'h000, 12'h024, 12'h028, 12'h02C, 12'h030,
    12'h034, 12'h038, 12'h044, 12'h048, 12'h04C, 12'h07C};

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check_all();
    // R2 shadows only
    wr(12'h024, 16'h1234); wr(12'h028, 16'h002A);
    rd(12'h024); rd(12'h028);
    check_outs();
    // R3 commit with FIFO enabled
    wr(12'h02C, 16'h0070);
    check_outs();
    // R5 both routes
    wr(12'h000, 16'hBEEF);
    wr(12'h02C, 16'h0060);
    wr(12'h000, 16'hCAFE);
    check_outs();
    // R4 locked writes, sticky flag
    wr(12'h030, 16'h0302);
    wr(12'h024, 16'h5555); wr(12'h02C, 16'h00FF);
    rd(12'h024); rd(12'h02C);
    check_outs();
    wr(12'h030, 16'h0300);
    check_outs();
    // R6 R7 status, mask, clear
    pulse(11'h405);
    wr(12'h038, 16'h0001);
    rd(12'h03C); rd(12'h040); check_outs();
    wr(12'h044, 16'h0000); rd(12'h03C);
    wr(12'h044, 16'h0001); rd(12'h03C); check_outs();
    // R6 set and clear on the same edge: set wins
    @(negedge clk); irq_set = 11'h004;
    wr(12'h044, 16'h0004);
    irq_set = 0;
    rd(12'h03C);
    // R9 reserved writes ignored, R10 ident bytes
    wr(12'h04C, 16'hFFFF); wr(12'h07C, 16'hFFFF);
    check_all();
    for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(4*k));
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) pulse(11'($urandom));
      else if (op == 1) rd(wr_list[$urandom_range(0, 10)]);
      else wr(wr_list[$urandom_range(0, 10)], 16'($urandom));
      if (n % 25 == 24) check_all();
    end
    check_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule